// File: doc/BRIEF.md
# Host Event Sideband Pulse Generator

This block turns the pending host-event state held by an embedded controller into sideband signals for the host chipset. The controller presents three event bitmaps: one for system-management events, one for ACPI events and one for wake events. It then strobes an update input. On each enabled update the block records whether each class has anything pending, drives the wake line as a level and asks for interrupt pulses. It also asks for an ACPI interrupt pulse whenever the ACPI mailbox reports that it has finished with a host byte.

SMI# and SCI# pulses are active low. Their length is a whole number of prescaler ticks, and both the tick length and the tick count are parameters. The defaults give 65 us at 100 MHz. That is longer than one period of a 32.768 kHz sampler and far longer than the 60 ns a 33 MHz sampler needs. The two pulse types follow different rules. An SMI pulse fires only when the SMI class goes from idle to pending. An SCI pulse fires on every update that carries SCI events. A request that arrives while a pulse of the same type is running is kept and issued after a short high gap.

Top module: `hev_sideband_pulse`

## Requirements
- R1: After reset, `smi_n`, `sci_n` and `wake_n` are high and both pending bits are 0.
- R2: While `enable` is low, `update` and `acpi_done` have no effect: no pulse starts, and the pending bits and `wake_n` keep their values.
- R3: An enabled update asks for an SMI pulse only when `smi_events` is non-zero and `smi_pending` was 0 before that update.
- R4: A pulse drives its output low for exactly PRESCALE*PULSE_TICKS cycles, starting in the cycle after the request when the channel is idle.
- R5: On each enabled update, `smi_pending` and `sci_pending` become the OR of their event vectors, so each bit clears when its vector is zero.
- R6: Every enabled update with a non-zero `sci_events` asks for an SCI pulse.
- R7: On each enabled update, `wake_n` becomes low exactly when `wake_events` has a bit set other than bit PWR_BIT, the power-button bit. Between enabled updates `wake_n` holds its value.
- R8: An `acpi_done` strobe with `enable` high asks for an SCI pulse.
- R9: Requests that arrive while a channel is pulsing or in its gap are merged into one held request. That request starts a new pulse as soon as the gap ends.
- R10: Between two pulses on the same output, the output stays high for at least PRESCALE cycles. When a held request follows, the gap is exactly PRESCALE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; strobes are ignored while low |
| update | input | 1 | One-cycle strobe: sample the event vectors |
| smi_events | input | EVT_W | Pending SMI-class events |
| sci_events | input | EVT_W | Pending SCI-class events |
| wake_events | input | EVT_W | Pending wake-class events |
| acpi_done | input | 1 | One-cycle strobe: ACPI mailbox finished a byte |
| smi_n | output | 1 | Active-low SMI pulse |
| sci_n | output | 1 | Active-low SCI pulse |
| wake_n | output | 1 | Active-low wake level |
| smi_pending | output | 1 | SMI class pending status bit |
| sci_pending | output | 1 | SCI class pending status bit |

## Verification
The bench repeats an SMI update while the class is already pending. A design that used the SCI rule for SMI would send a second pulse there. SCI requests are stacked inside a running pulse, and a design that dropped held requests would lose a pulse. A design that queued each request instead of merging them would give too many pulses. The bench measures the high gap before a held pulse, because a design that restarted at once would merge two pulses into one long low. Wake vectors that hold only the power-button bit must leave `wake_n` high, and strobes sent while disabled must leave every output untouched.

// File: rtl/hev_pkg.sv
package hev_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_LOW  = 2'd1,
        CH_GAP  = 2'd2
    } ch_state_e;

    localparam int NUM_CH = 2;
    localparam int CH_SMI = 0;
    localparam int CH_SCI = 1;

    typedef struct packed {
        logic sci;
        logic smi;
    } hev_req_t;

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/hev_prescale.sv
module hev_prescale #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    import hev_pkg::*;

    localparam int CW = cnt_width(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/hev_pulse_chan.sv
module hev_pulse_chan #(
    parameter int DIV         = 100,
    parameter int PULSE_TICKS = 65
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic pulse_n
);
    import hev_pkg::*;

    localparam int TW = cnt_width(PULSE_TICKS);
    localparam logic [TW-1:0] TLAST = TW'(PULSE_TICKS - 1);
    localparam int LOW_CYC = DIV * PULSE_TICKS;
    localparam int RW = cnt_width(LOW_CYC + 2);

    ch_state_e     state_q, state_d;
    logic [TW-1:0] tcnt_q, tcnt_d;
    logic          held_q, held_d;
    logic          restart;
    logic          tick;

    hev_prescale #(.DIV(DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .tick   (tick)
    );

    always_comb begin
        state_d = state_q;
        tcnt_d  = tcnt_q;
        held_d  = held_q;
        restart = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                if (req) begin
                    state_d = CH_LOW;
                    tcnt_d  = '0;
                    restart = 1'b1;
                end
            end
            CH_LOW: begin
                held_d = held_q | req;
                if (tick) begin
                    if (tcnt_q == TLAST) begin
                        state_d = CH_GAP;
                        restart = 1'b1;
                    end else begin
                        tcnt_d = tcnt_q + 1'b1;
                    end
                end
            end
            CH_GAP: begin
                if (tick) begin
                    if (held_q || req) begin
                        state_d = CH_LOW;
                        tcnt_d  = '0;
                        held_d  = 1'b0;
                        restart = 1'b1;
                    end else begin
                        state_d = CH_IDLE;
                    end
                end else begin
                    held_d = held_q | req;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_IDLE;
            tcnt_q  <= '0;
            held_q  <= 1'b0;
            pulse_n <= 1'b1;
        end else begin
            state_q <= state_d;
            tcnt_q  <= tcnt_d;
            held_q  <= held_d;
            pulse_n <= (state_d != CH_LOW);
        end
    end

    // Checker state: length of the current low run on the output.
    logic [RW-1:0] low_run;
    always_ff @(posedge clk) begin
        if (rst || pulse_n) low_run <= '0;
        else                low_run <= low_run + 1'b1;
    end

    p_width_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_n) |-> (low_run == RW'(LOW_CYC)));

    p_no_overrun_r4: assert property (@(posedge clk) disable iff (rst)
        !pulse_n |-> (low_run <= RW'(LOW_CYC)));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_IDLE && !req) |=> pulse_n);

    p_gap_after_rise_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_n) |-> (state_q == CH_GAP));

endmodule

// File: rtl/hev_event_eval.sv
module hev_event_eval #(
    parameter int EVT_W   = 32,
    parameter int PWR_BIT = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             update,
    input  logic [EVT_W-1:0] smi_events,
    input  logic [EVT_W-1:0] sci_events,
    input  logic [EVT_W-1:0] wake_events,
    input  logic             acpi_done,
    output hev_pkg::hev_req_t req,
    output logic             smi_pending,
    output logic             sci_pending,
    output logic             wake_n
);
    import hev_pkg::*;

    localparam logic [EVT_W-1:0] WAKE_MASK = ~(EVT_W'(1) << PWR_BIT);

    logic take;
    logic smi_any, sci_any, wake_any;

    assign take     = enable && update;
    assign smi_any  = |smi_events;
    assign sci_any  = |sci_events;
    assign wake_any = |(wake_events & WAKE_MASK);

    always_comb begin
        req.smi = take && smi_any && !smi_pending;
        req.sci = enable && ((update && sci_any) || acpi_done);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smi_pending <= 1'b0;
            sci_pending <= 1'b0;
            wake_n      <= 1'b1;
        end else if (take) begin
            smi_pending <= smi_any;
            sci_pending <= sci_any;
            wake_n      <= !wake_any;
        end
    end

    p_pend_smi_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(take)) |-> (smi_pending == (|$past(smi_events))));

    p_wake_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(wake_n));

    p_smi_edge_only_r3: assert property (@(posedge clk) disable iff (rst)
        req.smi |=> smi_pending);

endmodule

// File: rtl/hev_sideband_pulse.sv
module hev_sideband_pulse #(
    parameter int EVT_W       = 32,
    parameter int PWR_BIT     = 1,
    parameter int PRESCALE    = 100,
    parameter int PULSE_TICKS = 65
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             update,
    input  logic [EVT_W-1:0] smi_events,
    input  logic [EVT_W-1:0] sci_events,
    input  logic [EVT_W-1:0] wake_events,
    input  logic             acpi_done,
    output logic             smi_n,
    output logic             sci_n,
    output logic             wake_n,
    output logic             smi_pending,
    output logic             sci_pending
);
    import hev_pkg::*;

    hev_req_t            req;
    logic [NUM_CH-1:0]   req_vec;
    logic [NUM_CH-1:0]   pulse_vec;

    hev_event_eval #(.EVT_W(EVT_W), .PWR_BIT(PWR_BIT)) u_eval (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .update     (update),
        .smi_events (smi_events),
        .sci_events (sci_events),
        .wake_events(wake_events),
        .acpi_done  (acpi_done),
        .req        (req),
        .smi_pending(smi_pending),
        .sci_pending(sci_pending),
        .wake_n     (wake_n)
    );

    assign req_vec[CH_SMI] = req.smi;
    assign req_vec[CH_SCI] = req.sci;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        hev_pulse_chan #(.DIV(PRESCALE), .PULSE_TICKS(PULSE_TICKS)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .req    (req_vec[ch]),
            .pulse_n(pulse_vec[ch])
        );
    end

    assign smi_n = pulse_vec[CH_SMI];
    assign sci_n = pulse_vec[CH_SCI];

    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (smi_n && sci_n && wake_n && !smi_pending && !sci_pending));

    p_off_no_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!enable && smi_n) |=> smi_n);

endmodule

// File: tb/sim_hev_sideband_pulse.sv
module sim_hev_sideband_pulse;

    localparam int W  = 16;
    localparam int PB = 2;
    localparam int P  = 3;
    localparam int T  = 4;
    localparam int N  = P * T;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0, update = 1'b0, acpi_done = 1'b0;
    logic [W-1:0] smi_ev = '0, sci_ev = '0, wake_ev = '0;
    logic smi_n, sci_n, wake_n, smi_pending, sci_pending;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hev_sideband_pulse #(.EVT_W(W), .PWR_BIT(PB), .PRESCALE(P), .PULSE_TICKS(T)) u0 (
        .clk(clk), .rst(rst), .enable(enable), .update(update),
        .smi_events(smi_ev), .sci_events(sci_ev), .wake_events(wake_ev),
        .acpi_done(acpi_done), .smi_n(smi_n), .sci_n(sci_n), .wake_n(wake_n),
        .smi_pending(smi_pending), .sci_pending(sci_pending)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: per channel phase (0 idle, 1 low, 2 gap), cycles left, held flag.
    int ph[2], left[2];
    bit held[2];
    bit m_smi_p, m_sci_p, m_wake_n;

    function automatic void step(input int c, input bit r);
        case (ph[c])
            0: if (r) begin ph[c] = 1; left[c] = N; end
            1: begin
                if (r) held[c] = 1;
                left[c]--;
                if (left[c] == 0) begin ph[c] = 2; left[c] = P; end
            end
            default: begin
                left[c]--;
                if (left[c] == 0) begin
                    if (held[c] || r) begin ph[c] = 1; left[c] = N; held[c] = 0; end
                    else ph[c] = 0;
                end else if (r) held[c] = 1;
            end
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++) begin ph[c] = 0; left[c] = 0; held[c] = 0; end
            m_smi_p = 0; m_sci_p = 0; m_wake_n = 1;
        end else begin
            bit rs, rc;
            rs = enable && update && (smi_ev != 0) && !m_smi_p;
            rc = enable && ((update && (sci_ev != 0)) || acpi_done);
            step(0, rs);
            step(1, rc);
            if (enable && update) begin
                m_smi_p  = (smi_ev != 0);
                m_sci_p  = (sci_ev != 0);
                m_wake_n = ((wake_ev & ~(W'(1) << PB)) == 0);
            end
        end
    end

    // Per-cycle comparison and pulse measurement.
    int smi_falls = 0, sci_falls = 0;
    int sci_lo_run = 0, sci_hi_run = 0, last_gap = 0, last_width = 0;
    int smi_lo_run = 0, smi_width = 0;

    always @(negedge clk) begin
        if (!rst) begin
            check("R3 smi_n vs model", smi_n, (ph[0] != 1));
            check("R6 sci_n vs model", sci_n, (ph[1] != 1));
            check("R7 wake_n vs model", wake_n, m_wake_n);
            check("R5 smi_pending vs model", smi_pending, m_smi_p);
            check("R5 sci_pending vs model", sci_pending, m_sci_p);
            if (!sci_n) begin
                if (sci_lo_run == 0) begin sci_falls++; last_gap = sci_hi_run; end
                sci_lo_run++; sci_hi_run = 0;
            end else begin
                if (sci_lo_run != 0) last_width = sci_lo_run;
                sci_lo_run = 0; sci_hi_run++;
            end
            if (!smi_n) begin
                if (smi_lo_run == 0) smi_falls++;
                smi_lo_run++;
            end else begin
                if (smi_lo_run != 0) smi_width = smi_lo_run;
                smi_lo_run = 0;
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic do_update(input logic [W-1:0] s, input logic [W-1:0] c, input logic [W-1:0] w);
        @(posedge clk); #2;
        smi_ev = s; sci_ev = c; wake_ev = w; update = 1'b1;
        @(posedge clk); #2;
        update = 1'b0;
    endtask

    task automatic do_done();
        @(posedge clk); #2;
        acpi_done = 1'b1;
        @(posedge clk); #2;
        acpi_done = 1'b0;
    endtask

    initial begin
        int base;
        wait_cyc(4);
        check("R1 smi_n reset", smi_n, 1);
        check("R1 sci_n reset", sci_n, 1);
        check("R1 wake_n reset", wake_n, 1);
        check("R1 pending reset", {smi_pending, sci_pending}, 0);
        rst = 1'b0;

        // R2: disabled strobes do nothing
        do_update(16'h0001, 16'h0002, 16'h0010);
        do_done();
        wait_cyc(20);
        check("R2 no smi pulse", smi_falls, 0);
        check("R2 no sci pulse", sci_falls, 0);
        check("R2 wake held", wake_n, 1);
        check("R2 pending held", {smi_pending, sci_pending}, 0);

        enable = 1'b1;
        // R3 first SMI, R4 width
        do_update(16'h0001, 16'h0000, 16'h0000);
        wait_cyc(N + P + 4);
        check("R3 first smi pulse", smi_falls, 1);
        check("R4 smi width", smi_width, N);
        check("R5 smi pending set", smi_pending, 1);
        do_update(16'h0003, 16'h0000, 16'h0000);
        wait_cyc(N + P + 4);
        check("R3 no repeat smi", smi_falls, 1);
        do_update(16'h0000, 16'h0000, 16'h0000);
        wait_cyc(2);
        check("R5 smi pending clear", smi_pending, 0);
        do_update(16'h0004, 16'h0000, 16'h0000);
        wait_cyc(N + P + 4);
        check("R3 smi after clear", smi_falls, 2);

        // R6 SCI on every update
        base = sci_falls;
        do_update(16'h0004, 16'h0001, 16'h0000);
        wait_cyc(N + P + 4);
        do_update(16'h0004, 16'h0001, 16'h0000);
        wait_cyc(N + P + 4);
        check("R6 sci per update", sci_falls - base, 2);
        check("R4 sci width", last_width, N);
        do_update(16'h0004, 16'h0000, 16'h0000);
        wait_cyc(2);
        check("R5 sci pending clear", sci_pending, 0);

        // R8 mailbox completion
        base = sci_falls;
        do_done();
        wait_cyc(N + P + 4);
        check("R8 acpi_done pulse", sci_falls - base, 1);

        // R9 held and merged, R10 gap
        base = sci_falls;
        do_done();
        wait_cyc(2);
        do_done();
        wait_cyc(2);
        do_update(16'h0004, 16'h0008, 16'h0000);
        wait_cyc(3 * N + 4 * P);
        check("R9 merged held pulse", sci_falls - base, 2);
        check("R10 gap before held", last_gap, P);

        // R7 wake level with power-button masked
        do_update(16'h0000, 16'h0000, 16'h0004);
        wait_cyc(2);
        check("R7 power bit ignored", wake_n, 1);
        do_update(16'h0000, 16'h0000, 16'h0020);
        wait_cyc(2);
        check("R7 wake asserted", wake_n, 0);
        do_update(16'h0000, 16'h0000, 16'h0000);
        wait_cyc(N + P + 4);
        check("R7 wake released", wake_n, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule